// File: doc/BRIEF.md
# Global-History Correlating Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a short shift register of the most recent resolved branch outcomes across the whole program. That global history, combined with a few bits of the branch address, selects one saturating counter from an untagged table. The top bit of the selected counter is the prediction. The fetch side presents a PC on the predict port and reads a taken/not-taken answer in the same cycle. The execute side reports each resolved branch on the update port. That report nudges the counter it maps to and shifts the outcome into the history.

Two ways of forming the index are available, chosen by a parameter. The default places the history bits above the address bits, so each address slot owns 2^m counters, one per history pattern. The hashed variant XORs the history into a wider field of PC bits, which spreads branches across the whole table. In both variants the lowest PC bits (the byte offset within an instruction word) play no part. Branches that share an index share a counter, because the table holds no tags.

With m = 2 history bits, n = 2 counter bits and 4 address bits, the table has 64 counters, or 128 bits in total.

Top module: `corr_predictor`

## Requirements
- R1: After reset the history is all zeros and every counter holds the weakly-not-taken value (2^(n-1)-1, binary 01 for n = 2), so every PC predicts not taken.
- R2: `pred_taken` is the most significant bit of the counter selected by `pred_pc` and the current history; it is combinational from those and the stored state.
- R3: An update with `upd_taken` = 1 increments the selected counter, and a counter already at its maximum (all ones) stays there.
- R4: An update with `upd_taken` = 0 decrements the selected counter, and a counter already at zero stays there.
- R5: Each update shifts its outcome into history bit 0 and moves every other bit up one place, dropping the oldest; bit k therefore holds the outcome of the (k+1)-th most recent update.
- R6: In the default mode (`IDX_MODE` = IDX_CONCAT) the index is {history, pc[PC_SKIP+ADDR_W-1 : PC_SKIP]}: the history forms the upper bits, and PC bits below PC_SKIP (2 by default) do not affect the result.
- R7: Entries carry no tag, so two PCs that produce the same index read and train the same counter.
- R8: An update takes effect at the next clock edge. A prediction made in the same cycle sees the counters and history from before that update. The update itself selects its counter with the history from before its own shift.
- R9: In the hashed mode (`IDX_MODE` = IDX_XOR) the index is pc[PC_SKIP+m+ADDR_W-1 : PC_SKIP] XOR the history, with the history zero-extended on the upper side.
- R10: When `upd_valid` is 0, neither the counters nor the history change, whatever `upd_pc` and `upd_taken` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | PC_W | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The bench drives a counter up past its ceiling and down past its floor. A design that wrapped at either end would flip its prediction at exactly that point. It predicts and updates the same index in one cycle, which catches a design that forwards the new counter value or indexes the update with the already-shifted history. It trains one PC and then predicts for PCs that differ only in the byte-offset bits or only above the index field. A design that used the wrong slice of the address, or ordered the history and address bits the other way, would predict differently for those PCs. Both index modes run against one reference model under the same stream, together with cycles where the update data is present but `upd_valid` is low. A design with a wrong XOR alignment, or one that trained without the strobe, would give predictions that drift from the model.

// File: rtl/corr_pred_pkg.sv
package corr_pred_pkg;

    // How the history is merged with the branch address to form a table index
    typedef enum logic {
        IDX_CONCAT = 1'b0,
        IDX_XOR    = 1'b1
    } idx_mode_e;

    // Weakly-not-taken reset value of an n-bit counter: 0 followed by ones
    function automatic int unsigned weak_not_taken(input int unsigned ctr_w);
        return (32'd1 << (ctr_w - 1)) - 32'd1;
    endfunction

endpackage

// File: rtl/ghist_reg.sv
module ghist_reg #(
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              outcome,
    output logic [HIST_W-1:0] hist
);

    logic [HIST_W-1:0] hist_nxt;

    generate
        if (HIST_W == 1) begin : g_single
            always_comb hist_nxt = outcome;
        end else begin : g_multi
            always_comb hist_nxt = {hist[HIST_W-2:0], outcome};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (shift_en) begin
            hist <= hist_nxt;
        end
    end

endmodule

// File: rtl/pred_index.sv
module pred_index
    import corr_pred_pkg::*;
#(
    parameter int        HIST_W   = 2,
    parameter int        ADDR_W   = 4,
    parameter idx_mode_e IDX_MODE = IDX_CONCAT,
    parameter int        IDX_W    = HIST_W + ADDR_W
) (
    input  logic [IDX_W-1:0]  pc_fld,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);

    generate
        if (IDX_MODE == IDX_XOR) begin : g_xor
            logic [IDX_W-1:0] hist_ext;
            always_comb begin
                hist_ext = {{ADDR_W{1'b0}}, hist};
                idx      = pc_fld ^ hist_ext;
            end
        end else begin : g_concat
            logic unused_pc_hi;
            assign unused_pc_hi = ^pc_fld[IDX_W-1:ADDR_W];
            always_comb idx = {hist, pc_fld[ADDR_W-1:0]};
        end
    endgenerate

endmodule

// File: rtl/ctr_step.sv
module ctr_step #(
    parameter int CTR_W = 2
) (
    input  logic [CTR_W-1:0] cur,
    input  logic             up,
    output logic [CTR_W-1:0] nxt
);

    localparam logic [CTR_W-1:0] CTR_MAX = '1;
    localparam logic [CTR_W-1:0] CTR_MIN = '0;

    always_comb begin
        nxt = cur;
        if (up) begin
            if (cur != CTR_MAX) nxt = cur + 1'b1;
        end else begin
            if (cur != CTR_MIN) nxt = cur - 1'b1;
        end
    end

endmodule

// File: rtl/ctr_table.sv
module ctr_table #(
    parameter int             IDX_W   = 6,
    parameter int             CTR_W   = 2,
    parameter logic [CTR_W-1:0] RST_VAL = '0,
    parameter int             DEPTH   = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_p_idx,
    output logic [CTR_W-1:0] rd_p_ctr,
    input  logic [IDX_W-1:0] rd_u_idx,
    output logic [CTR_W-1:0] rd_u_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CTR_W-1:0] wr_ctr
);

    logic [CTR_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= RST_VAL;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= wr_ctr;
        end
    end

    assign rd_p_ctr = mem[rd_p_idx];
    assign rd_u_ctr = mem[rd_u_idx];

endmodule

// File: rtl/corr_predictor.sv
module corr_predictor
    import corr_pred_pkg::*;
#(
    parameter int        HIST_W   = 2,
    parameter int        CTR_W    = 2,
    parameter int        ADDR_W   = 4,
    parameter int        PC_W     = 32,
    parameter int        PC_SKIP  = 2,
    parameter idx_mode_e IDX_MODE = IDX_CONCAT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);

    localparam int               IDX_W   = HIST_W + ADDR_W;
    localparam logic [CTR_W-1:0] CTR_RST = CTR_W'(weak_not_taken(CTR_W));

    logic [HIST_W-1:0] hist_q;
    logic [IDX_W-1:0]  pred_idx;
    logic [IDX_W-1:0]  upd_idx;
    logic [CTR_W-1:0]  pred_ctr;
    logic [CTR_W-1:0]  upd_ctr_cur;
    logic [CTR_W-1:0]  upd_ctr_nxt;
    logic              unused_pc_bits;

    assign unused_pc_bits = ^{pred_pc, upd_pc};

    ghist_reg #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (upd_valid),
        .outcome  (upd_taken),
        .hist     (hist_q)
    );

    pred_index #(.HIST_W(HIST_W), .ADDR_W(ADDR_W), .IDX_MODE(IDX_MODE)) u_pidx (
        .pc_fld (pred_pc[PC_SKIP +: IDX_W]),
        .hist   (hist_q),
        .idx    (pred_idx)
    );

    pred_index #(.HIST_W(HIST_W), .ADDR_W(ADDR_W), .IDX_MODE(IDX_MODE)) u_uidx (
        .pc_fld (upd_pc[PC_SKIP +: IDX_W]),
        .hist   (hist_q),
        .idx    (upd_idx)
    );

    ctr_table #(.IDX_W(IDX_W), .CTR_W(CTR_W), .RST_VAL(CTR_RST)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_p_idx (pred_idx),
        .rd_p_ctr (pred_ctr),
        .rd_u_idx (upd_idx),
        .rd_u_ctr (upd_ctr_cur),
        .wr_en    (upd_valid),
        .wr_idx   (upd_idx),
        .wr_ctr   (upd_ctr_nxt)
    );

    ctr_step #(.CTR_W(CTR_W)) u_step (
        .cur (upd_ctr_cur),
        .up  (upd_taken),
        .nxt (upd_ctr_nxt)
    );

    assign pred_taken = pred_ctr[CTR_W-1];

endmodule

// File: rtl/corr_predictor_chk.sv
module corr_predictor_chk #(
    parameter int HIST_W = 2,
    parameter int CTR_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              upd_valid,
    input logic              upd_taken,
    input logic [HIST_W-1:0] hist,
    input logic [CTR_W-1:0]  upd_old,
    input logic [CTR_W-1:0]  upd_new
);

    localparam logic [CTR_W-1:0] CTR_MAX = '1;

    // R5
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (hist[0] == $past(upd_taken)) &&
                      (hist[HIST_W-1:1] == $past(hist[HIST_W-2:0])));

    // R10
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(hist));

    // R3
    ctr_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken) |-> (int'(upd_new) >= int'(upd_old)) &&
                                     (int'(upd_new) - int'(upd_old) <= 1));

    // R3
    ctr_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && upd_old == CTR_MAX) |-> upd_new == CTR_MAX);

    // R4
    ctr_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken) |-> (int'(upd_new) <= int'(upd_old)) &&
                                      (int'(upd_old) - int'(upd_new) <= 1));

    // R4
    ctr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && upd_old == '0) |-> upd_new == '0);

endmodule

bind corr_predictor corr_predictor_chk #(.HIST_W(HIST_W), .CTR_W(CTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_valid),
    .upd_taken (upd_taken),
    .hist      (hist_q),
    .upd_old   (upd_ctr_cur),
    .upd_new   (upd_ctr_nxt)
);

// File: tb/corr_predictor_bench.sv
module corr_predictor_bench;

    localparam int HW = 2;
    localparam int CW = 2;
    localparam int AW = 4;
    localparam int PW = 32;
    localparam int SK = 2;
    localparam int IW = HW + AW;
    localparam int NE = 1 << IW;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] pred_pc = '0;
    logic [PW-1:0] upd_pc = '0;
    logic          upd_valid = 1'b0;
    logic          upd_taken = 1'b0;
    logic          pt_cat;
    logic          pt_xor;

    always #5 clk = ~clk;

    corr_predictor u_corr_predictor (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pt_cat),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    corr_predictor #(.IDX_MODE(corr_pred_pkg::IDX_XOR)) u_corr_predictor_xor (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pt_xor),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    // Reference model
    int          m_cat [NE];
    int          m_xor [NE];
    logic [HW-1:0] m_hist;

    bit    exp_cat_q [$];
    bit    exp_xor_q [$];
    string tag_q [$];

    int n_chk  = 0;
    int n_fail = 0;

    function automatic int ix_cat(input logic [PW-1:0] pc, input logic [HW-1:0] h);
        logic [IW-1:0] v;
        v = {h, pc[SK+AW-1:SK]};
        return int'(v);
    endfunction

    function automatic int ix_xor(input logic [PW-1:0] pc, input logic [HW-1:0] h);
        logic [IW-1:0] v;
        v = pc[SK+IW-1:SK] ^ {{AW{1'b0}}, h};
        return int'(v);
    endfunction

    task automatic check(input string tag, input bit act, input bit exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus, expected result queued before the model update
    task automatic step(input logic [PW-1:0] ppc, input logic uv,
                        input logic [PW-1:0] upc, input logic ut, input string tag);
        int a;
        int b;
        @(negedge clk);
        pred_pc   = ppc;
        upd_valid = uv;
        upd_pc    = upc;
        upd_taken = ut;
        exp_cat_q.push_back(m_cat[ix_cat(ppc, m_hist)] > CMAX / 2);
        exp_xor_q.push_back(m_xor[ix_xor(ppc, m_hist)] > CMAX / 2);
        tag_q.push_back(tag);
        if (uv) begin
            a = ix_cat(upc, m_hist);
            b = ix_xor(upc, m_hist);
            if (ut) begin
                if (m_cat[a] < CMAX) m_cat[a]++;
                if (m_xor[b] < CMAX) m_xor[b]++;
            end else begin
                if (m_cat[a] > 0) m_cat[a]--;
                if (m_xor[b] > 0) m_xor[b]--;
            end
            m_hist = {m_hist[HW-2:0], ut};
        end
    endtask

    // Monitor: compares just before the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            #4;
            if (exp_cat_q.size() > 0) begin
                string t;
                bit ec;
                bit ex;
                t  = tag_q.pop_front();
                ec = exp_cat_q.pop_front();
                ex = exp_xor_q.pop_front();
                check({t, " concat"}, pt_cat, ec);
                check({"R9 xor with ", t}, pt_xor, ex);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    localparam logic [PW-1:0] PC_A = 32'h0000_0040;
    localparam logic [PW-1:0] PC_B = 32'h0000_0044;
    localparam logic [PW-1:0] PC_C = 32'h0000_0078;

    initial begin
        for (int i = 0; i < NE; i++) begin
            m_cat[i] = (1 << (CW - 1)) - 1;
            m_xor[i] = (1 << (CW - 1)) - 1;
        end
        m_hist = '0;

        // R1: during reset, and right after it
        #12;
        check("R1 in reset A", pt_cat, 1'b0);
        pred_pc = 32'hFFFF_FFFC;
        #1;
        check("R1 in reset high pc", pt_xor, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        step(PC_A, 1'b0, '0, 1'b0, "R1");
        step(32'hFFFF_FFFC, 1'b0, '0, 1'b0, "R1");

        // R3: train A taken past saturation
        for (int i = 0; i < 6; i++) step(PC_A, 1'b1, PC_A, 1'b1, "R3");

        // R8: same-cycle predict and update
        step(PC_A, 1'b1, PC_A, 1'b0, "R8");
        step(PC_A, 1'b1, PC_A, 1'b0, "R8");
        step(PC_A, 1'b0, PC_A, 1'b0, "R8");

        // R4: drive past the floor
        for (int i = 0; i < 7; i++) step(PC_A, 1'b1, PC_A, 1'b0, "R4");

        // R5: alternating outcomes select different counters by history
        for (int i = 0; i < 10; i++) step(PC_B, 1'b1, PC_B, (i % 2 == 0), "R5");
        for (int i = 0; i < 4; i++) step(PC_B, 1'b1, PC_B, (i % 3 != 0), "R5");

        // R6: byte-offset bits ignored
        for (int i = 0; i < 4; i++) step(PC_C, 1'b1, PC_C, 1'b1, "R6");
        step(PC_C | 32'h3, 1'b0, '0, 1'b0, "R6");
        step(PC_C | 32'h1, 1'b0, '0, 1'b0, "R6");

        // R7: PCs differing only above the index field share a counter
        for (int i = 0; i < 4; i++) step(PC_A | 32'h0001_0000, 1'b1, PC_A | 32'h0001_0000, 1'b1, "R7");
        step(PC_A, 1'b0, '0, 1'b0, "R7");
        step(PC_A | 32'h0100_0000, 1'b0, '0, 1'b0, "R7");

        // R10: update data present but strobe low
        for (int i = 0; i < 3; i++) step(PC_A, 1'b0, PC_A, 1'b0, "R10");
        for (int i = 0; i < 3; i++) step(PC_B, 1'b0, PC_B, 1'b1, "R10");

        // R2 / R9: mixed addresses through both index modes
        for (int i = 0; i < 40; i++) begin
            logic [PW-1:0] p;
            p = 32'h0000_1000 + 32'(i * 36);
            step(p, 1'b1, 32'h0000_1000 + 32'((i * 52) % 256), ((i * 7) % 5) < 3, "R2");
        end

        step(PC_A, 1'b0, '0, 1'b0, "R2");
        @(negedge clk);
        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule